// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block holds a small set of event counters behind a single 32-bit register window. Software first writes a selector register with a counter number. After that, the count, configuration and threshold registers it accesses all belong to that counter. Each counter watches one line of an event-pulse vector, chosen by a condition number, and can be limited to kernel-mode or user-mode cycles. A global run bit starts and stops every counter together.

Counters are 32 + 16·S bits wide. The full value is written as a low word and a high word. Reads are made safe by a snapshot: a control write copies the selected counter into a two-word holding register in one cycle. Each counter also has a threshold. When an increment lands exactly on the threshold, the counter's active flag is set. Active flags AND-ed with their enables drive one interrupt line. Clearing an active flag (write 1) also drops its enable. A read-only build word describes the configuration. An 8-character name can be read for each condition index.

Register word addresses: 0 build, 1 control, 2 counter select, 3 config, 4/5 count low/high, 6/7 threshold low/high, 8/9 snapshot low/high, 10 interrupt enable, 11 interrupt active, 12 condition select, 13/14 condition name words.

Top module: `perf_cnt_bank`

## Requirements
- R1: The build word at address 0 reads bit0=1 (counters present), bit1=HAS_IRQ, bits 9:4 = NUM_CNT, bits 13:12 = SIZE_S and bits 23:16 = NUM_COND; with defaults it is 0x0008_1043.
- R2: Count, config and threshold accesses go only to the counter named in the select register (address 2). With a select value of NUM_CNT or more, writes to those registers are dropped and reads return 0.
- R3: Control bit 0 is the global run bit. While it is 0, no counter changes except by a register write.
- R4: A counter whose config bits 7:0 hold condition c (1 ≤ c < NUM_COND) adds exactly one in each cycle where event_i[c] is high. Condition 0 never counts.
- R5: Config bit 8 limits counting to cycles with priv_kernel_i=1, and config bit 9 limits it to cycles with priv_kernel_i=0. With both bits set the counter never counts; with neither set the mode is ignored.
- R6: Writing address 4 replaces count bits 31:0, and writing address 5 replaces the upper 16·S bits. In the same cycle such a write wins over an increment. The count wraps to 0 after all ones.
- R7: Writing control bit 1 copies the selected counter's full value, as held before that cycle's increment, into snapshot low (8) and high (9). Control bit 1 always reads 0.
- R8: An increment that makes a count equal to its threshold sets that counter's bit in the active register (11), whatever the state of the enable bits.
- R9: irq_o is high exactly when some counter has both its active bit and its enable bit (address 10) set.
- R10: Writing 1s to address 11 clears those active bits and the same enable bits. Bits written as 0 are left unchanged.
- R11: After a condition index k (< NUM_COND) is written to address 12, name word 13 reads 0x646E6F63 ("cond"). Name word 14 holds the upper hex digit of k in bits 7:0, the lower hex digit in bits 15:8, and zeros above. Indexes of NUM_COND or more read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| event_i | input | NUM_COND | Event pulses, one per condition index |
| priv_kernel_i | input | 1 | 1 in kernel mode, 0 in user mode |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
Every condition number is swept over separate counters, each driven by its own multiplied-and-folded event pattern. A wrong line choice, a missing "never" for condition 0, or a leak between counters therefore gives a different count. The four filter settings are crossed with both privilege levels to separate the kernel-only, user-only, both and neither cases. Values placed just below the 32-bit boundary and at all-ones test the carry into the high half and the wrap, and also show whether the snapshot holds the value from before later events. A threshold run first with the enable off and then with it on separates setting the active flag from raising the interrupt, and a final clear checks that the enable is lost.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;

  localparam logic [3:0] A_BUILD = 4'd0;
  localparam logic [3:0] A_CTRL  = 4'd1;
  localparam logic [3:0] A_SEL   = 4'd2;
  localparam logic [3:0] A_CFG   = 4'd3;
  localparam logic [3:0] A_CNTL  = 4'd4;
  localparam logic [3:0] A_CNTH  = 4'd5;
  localparam logic [3:0] A_THRL  = 4'd6;
  localparam logic [3:0] A_THRH  = 4'd7;
  localparam logic [3:0] A_SNPL  = 4'd8;
  localparam logic [3:0] A_SNPH  = 4'd9;
  localparam logic [3:0] A_IEN   = 4'd10;
  localparam logic [3:0] A_IACT  = 4'd11;
  localparam logic [3:0] A_CSEL  = 4'd12;
  localparam logic [3:0] A_NAM0  = 4'd13;
  localparam logic [3:0] A_NAM1  = 4'd14;

  localparam logic [31:0] NAME_STEM = 32'h646E_6F63;

  typedef struct packed {
    logic       uonly;
    logic       konly;
    logic [7:0] cond;
  } cnt_cfg_t;

  function automatic logic priv_match(input cnt_cfg_t c, input logic kern);
    return (!c.konly || kern) && (!c.uonly || !kern);
  endfunction

  function automatic logic [7:0] hex_ch(input logic [3:0] d);
    return (d < 4'd10) ? (8'h30 + {4'h0, d}) : (8'h37 + {4'h0, d});
  endfunction

  function automatic logic [31:0] name_hi(input logic [7:0] idx);
    return {16'h0000, hex_ch(idx[3:0]), hex_ch(idx[7:4])};
  endfunction

  function automatic logic [31:0] build_word(input int ncnt, input int s,
                                             input int ncond, input bit irq);
    logic [31:0] w;
    w = '0;
    w[0] = 1'b1;
    w[1] = irq;
    w[9:4] = 6'(ncnt);
    w[13:12] = 2'(s);
    w[23:16] = 8'(ncond);
    return w;
  endfunction

endpackage

// File: rtl/perf_cnt_slot.sv
module perf_cnt_slot
  import perf_cnt_pkg::*;
#(
  parameter int CW       = 48,
  parameter int NUM_COND = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [NUM_COND-1:0] ev,
  input  logic                priv_k,
  input  logic                wr_cfg,
  input  logic                wr_cnt_lo,
  input  logic                wr_cnt_hi,
  input  logic                wr_thr_lo,
  input  logic                wr_thr_hi,
  input  logic [31:0]         wdata,
  output logic [CW-1:0]       cnt_o,
  output logic [CW-1:0]       thr_o,
  output cnt_cfg_t            cfg_o,
  output logic                inc_o,
  output logic                hit_o
);
  localparam int HW = CW - 32;

  cnt_cfg_t      cfg_q;
  logic [CW-1:0] cnt_q, thr_q, cnt_inc;
  logic          ev_hit, step;

  // condition 0 is never matched: the scan starts at index 1
  always_comb begin
    ev_hit = 1'b0;
    for (int k = 1; k < NUM_COND; k++)
      if (cfg_q.cond == 8'(k)) ev_hit = ev[k];
  end

  assign step    = run && ev_hit && priv_match(cfg_q, priv_k);
  assign cnt_inc = cnt_q + 1'b1;
  assign inc_o   = step;
  assign hit_o   = step && !wr_cnt_lo && !wr_cnt_hi && (cnt_inc == thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      thr_q <= '0;
    end else begin
      if (wr_cfg)    cfg_q <= cnt_cfg_t'(wdata[9:0]);
      if (wr_thr_lo) thr_q[31:0] <= wdata;
      if (wr_thr_hi) thr_q[CW-1:32] <= wdata[HW-1:0];
      if (wr_cnt_lo)      cnt_q[31:0] <= wdata;
      else if (wr_cnt_hi) cnt_q[CW-1:32] <= wdata[HW-1:0];
      else if (step)      cnt_q <= cnt_inc;
    end
  end

  assign cnt_o = cnt_q;
  assign thr_o = thr_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/perf_irq_ctl.sv
module perf_irq_ctl #(
  parameter int N       = 4,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         wr_en,
  input  logic         wr_act,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] act_q,
  output logic [N-1:0] clr_mask,
  output logic         irq
);
  generate
    if (HAS_IRQ) begin : g_irq
      logic [N-1:0] en_r, act_r;
      assign clr_mask = wr_act ? wdata : '0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_r  <= '0;
          act_r <= '0;
        end else begin
          // a fresh hit wins over a clear in the same cycle
          act_r <= (act_r & ~clr_mask) | hit;
          en_r  <= (wr_en ? wdata : en_r) & ~clr_mask;
        end
      end
      assign en_q  = en_r;
      assign act_q = act_r;
      assign irq   = |(act_r & en_r);
    end else begin : g_noirq
      assign clr_mask = '0;
      assign en_q     = '0;
      assign act_q    = '0;
      assign irq      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
  import perf_cnt_pkg::*;
#(
  parameter int NUM_CNT  = 4,
  parameter int SIZE_S   = 1,
  parameter int NUM_COND = 8,
  parameter bit HAS_IRQ  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:0] event_i,
  input  logic                priv_kernel_i,
  output logic                irq_o
);
  localparam int CW = 32 + 16 * SIZE_S;
  localparam logic [31:0] BUILD = build_word(NUM_CNT, SIZE_S, NUM_COND, HAS_IRQ);

  logic          run_q;
  logic [4:0]    sel_q;
  logic [7:0]    csel_q;
  logic [CW-1:0] snap_q;
  logic          sel_ok;

  logic wr_ctrl, wr_sel, wr_cfg, wr_cntl, wr_cnth, wr_thrl, wr_thrh;
  logic wr_ien, wr_iact, wr_csel, cnt_wr;

  logic [CW-1:0] cnt_arr [NUM_CNT];
  logic [CW-1:0] thr_arr [NUM_CNT];
  cnt_cfg_t      cfg_arr [NUM_CNT];
  logic [NUM_CNT-1:0]    inc_vec, hit_vec, en_q, act_q, clr_mask;
  logic [NUM_CNT*CW-1:0] cnt_flat;

  logic [CW-1:0] cnt_sel, thr_sel;
  cnt_cfg_t      cfg_sel;

  assign sel_ok  = (sel_q < 5'(NUM_CNT));
  assign wr_ctrl = reg_wen && (reg_addr == A_CTRL);
  assign wr_sel  = reg_wen && (reg_addr == A_SEL);
  assign wr_cfg  = reg_wen && (reg_addr == A_CFG);
  assign wr_cntl = reg_wen && (reg_addr == A_CNTL);
  assign wr_cnth = reg_wen && (reg_addr == A_CNTH);
  assign wr_thrl = reg_wen && (reg_addr == A_THRL);
  assign wr_thrh = reg_wen && (reg_addr == A_THRH);
  assign wr_ien  = reg_wen && (reg_addr == A_IEN);
  assign wr_iact = reg_wen && (reg_addr == A_IACT);
  assign wr_csel = reg_wen && (reg_addr == A_CSEL);
  assign cnt_wr  = wr_cntl || wr_cnth;

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
      logic hit_me;
      assign hit_me = sel_ok && (sel_q == 5'(i));
      perf_cnt_slot #(.CW(CW), .NUM_COND(NUM_COND)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .ev        (event_i),
        .priv_k    (priv_kernel_i),
        .wr_cfg    (wr_cfg  && hit_me),
        .wr_cnt_lo (wr_cntl && hit_me),
        .wr_cnt_hi (wr_cnth && hit_me),
        .wr_thr_lo (wr_thrl && hit_me),
        .wr_thr_hi (wr_thrh && hit_me),
        .wdata     (reg_wdata),
        .cnt_o     (cnt_arr[i]),
        .thr_o     (thr_arr[i]),
        .cfg_o     (cfg_arr[i]),
        .inc_o     (inc_vec[i]),
        .hit_o     (hit_vec[i])
      );
      assign cnt_flat[i*CW +: CW] = cnt_arr[i];
    end
  endgenerate

  perf_irq_ctl #(.N(NUM_CNT), .HAS_IRQ(HAS_IRQ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_vec),
    .wr_en    (wr_ien),
    .wr_act   (wr_iact),
    .wdata    (reg_wdata[NUM_CNT-1:0]),
    .en_q     (en_q),
    .act_q    (act_q),
    .clr_mask (clr_mask),
    .irq      (irq_o)
  );

  always_comb begin
    cnt_sel = '0;
    thr_sel = '0;
    cfg_sel = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == 5'(i)) begin
        cnt_sel = cnt_arr[i];
        thr_sel = thr_arr[i];
        cfg_sel = cfg_arr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      csel_q <= '0;
      snap_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[0];
        if (reg_wdata[1]) snap_q <= cnt_sel;
      end
      if (wr_sel)  sel_q  <= reg_wdata[4:0];
      if (wr_csel) csel_q <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_BUILD: reg_rdata = BUILD;
      A_CTRL:  reg_rdata = {31'h0, run_q};
      A_SEL:   reg_rdata = {27'h0, sel_q};
      A_CFG:   reg_rdata = 32'(cfg_sel);
      A_CNTL:  reg_rdata = cnt_sel[31:0];
      A_CNTH:  reg_rdata = 32'(cnt_sel[CW-1:32]);
      A_THRL:  reg_rdata = thr_sel[31:0];
      A_THRH:  reg_rdata = 32'(thr_sel[CW-1:32]);
      A_SNPL:  reg_rdata = snap_q[31:0];
      A_SNPH:  reg_rdata = 32'(snap_q[CW-1:32]);
      A_IEN:   reg_rdata = 32'(en_q);
      A_IACT:  reg_rdata = 32'(act_q);
      A_CSEL:  reg_rdata = {24'h0, csel_q};
      A_NAM0:  reg_rdata = (csel_q < 8'(NUM_COND)) ? NAME_STEM : '0;
      A_NAM1:  reg_rdata = (csel_q < 8'(NUM_COND)) ? name_hi(csel_q) : '0;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/perf_cnt_bank_chk.sv
module perf_cnt_bank_chk #(
  parameter int N       = 4,
  parameter int CW      = 48,
  parameter bit HAS_IRQ = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_q,
  input logic            cnt_wr,
  input logic [N*CW-1:0] cnt_flat,
  input logic [N-1:0]    inc_vec,
  input logic [N-1:0]    hit_vec,
  input logic [N-1:0]    en_q,
  input logic [N-1:0]    act_q,
  input logic [N-1:0]    clr_mask,
  input logic [3:0]      reg_addr,
  input logic            snap_bit_rd
);
  // R3: stopped bank holds every value unless software writes a count
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt_flat));

  // R3: no counter requests a step while the run bit is low
  p_stop_noinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (inc_vec == '0));

  // R7: snapshot trigger bit reads back as zero
  p_snap_rd0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd1) |-> !snap_bit_rd);

  generate
    for (genvar i = 0; i < N; i++) begin : g_c
      // R4: without a count write, a counter moves by at most one per cycle
      p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW])) ||
                     (cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW]) + 1'b1)));
    end
    if (HAS_IRQ) begin : g_irq
      // R8: a threshold hit latches active regardless of enable
      p_hit_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |=> ((act_q & $past(hit_vec)) == $past(hit_vec)));
      // R10: clearing an active bit also drops its enable
      p_clr_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((en_q & $past(clr_mask)) == '0));
      p_clr_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((act_q & $past(clr_mask) & ~$past(hit_vec)) == '0));
    end
  endgenerate
endmodule

bind perf_cnt_bank perf_cnt_bank_chk #(.N(NUM_CNT), .CW(CW), .HAS_IRQ(HAS_IRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_q       (run_q),
  .cnt_wr      (cnt_wr),
  .cnt_flat    (cnt_flat),
  .inc_vec     (inc_vec),
  .hit_vec     (hit_vec),
  .en_q        (en_q),
  .act_q       (act_q),
  .clr_mask    (clr_mask),
  .reg_addr    (reg_addr),
  .snap_bit_rd (reg_rdata[1])
);

// File: tb/sim_perf_cnt_bank.sv
`timescale 1ns/1ps
module sim_perf_cnt_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  event_i = '0;
  logic        priv_kernel_i = 1'b1;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_cnt_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_i(event_i),
    .priv_kernel_i(priv_kernel_i), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'd4, lo);
    rd(4'd5, hi);
    v = {16'h0, hi[15:0], lo};
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * seed) ^ (k >> 1));
  endfunction

  function automatic int exp_cnt(input int c, input int n, input int seed);
    int s = 0;
    if (c == 0) return 0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] p;
      p = pat(k, seed);
      s += int'(p[c]);
    end
    return s;
  endfunction

  task automatic pulses(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      event_i = pat(k, seed);
    end
    @(negedge clk);
    event_i = '0;
  endtask

  task automatic const_ev(input int n, input logic [7:0] v);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      event_i = v;
    end
    @(negedge clk);
    event_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state and R1 build word
    rd(4'd0, d); check("R1 build word", 64'(d), 64'h0008_1043);
    rd_cnt(v);   check("R6 reset count", v, 64'h0);
    check("R9 reset irq", 64'(irq_o), 64'h0);
    rd(4'd1, d); check("R3 reset run bit", 64'(d), 64'h0);

    // R4 sweep of every condition number over the counters
    wr(4'd1, 32'h1);
    priv_kernel_i = 1'b1;
    for (int c = 0; c < 8; c++) begin
      wr(4'd2, 32'(c % 4));
      wr(4'd4, 32'h0); wr(4'd5, 32'h0);
      wr(4'd3, 32'(c));
      pulses(20, 2 * c + 3);
      wr(4'd3, 32'h0);
      rd_cnt(v);
      check($sformatf("R4 cond %0d count", c), v, 64'(exp_cnt(c, 20, 2 * c + 3)));
    end

    // R2 out-of-range select drops writes and reads zero
    wr(4'd2, 32'd7);
    wr(4'd4, 32'h55);
    rd_cnt(v); check("R2 out-of-range read", v, 64'h0);
    for (int i = 0; i < 4; i++) begin
      wr(4'd2, 32'(i));
      rd_cnt(v);
      check($sformatf("R2 counter %0d kept", i), v, 64'(exp_cnt(i + 4, 20, 2 * (i + 4) + 3)));
    end

    // R5 privilege filter sweep on counter 0, condition 1
    wr(4'd2, 32'h0);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        bit ok;
        ok = (!(m & 1) || p == 1) && (!(m & 2) || p == 0);
        wr(4'd4, 32'h0); wr(4'd5, 32'h0);
        wr(4'd3, 32'((m << 8) | 1));
        priv_kernel_i = p[0];
        const_ev(5, 8'hFF);
        rd_cnt(v);
        check($sformatf("R5 mode %0d priv %0d", m, p), v, ok ? 64'd5 : 64'd0);
      end
    end
    priv_kernel_i = 1'b1;
    wr(4'd3, 32'h1);

    // R3 global stop
    wr(4'd4, 32'h0);
    wr(4'd1, 32'h0);
    const_ev(6, 8'hFF);
    rd_cnt(v); check("R3 stopped bank", v, 64'h0);
    wr(4'd1, 32'h1);

    // R6 wrap at full width
    wr(4'd5, 32'hFFFF); wr(4'd4, 32'hFFFF_FFFF);
    const_ev(1, 8'h02);
    rd_cnt(v); check("R6 wrap to zero", v, 64'h0);

    // R6 write wins over same-cycle increment
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd100; event_i = 8'hFF;
    @(negedge clk);
    reg_wen = 1'b0; event_i = '0;
    rd_cnt(v); check("R6 write priority", v, 64'd100);

    // R7 snapshot across the low/high boundary
    wr(4'd5, 32'h12); wr(4'd4, 32'hFFFF_FFFE);
    const_ev(3, 8'h02);
    rd_cnt(v); check("R6 carry into high half", v, 64'h13_0000_0001);
    wr(4'd1, 32'h3);
    const_ev(4, 8'h02);
    rd(4'd8, d); v[31:0] = d;
    rd(4'd9, d); v[63:32] = 32'(d[15:0]);
    check("R7 snapshot value", v, 64'h13_0000_0001);
    rd(4'd1, d); check("R7 snap bit reads 0", 64'(d), 64'h1);
    rd_cnt(v); check("R7 live count moved on", v, 64'h13_0000_0005);
    wr(4'd3, 32'h0);

    // R8 R9 R10 threshold, interrupt, clear
    wr(4'd11, 32'hF);
    wr(4'd10, 32'h0);
    wr(4'd2, 32'h2);
    wr(4'd4, 32'h0); wr(4'd5, 32'h0);
    wr(4'd6, 32'd5); wr(4'd7, 32'h0);
    wr(4'd3, 32'h3);
    const_ev(4, 8'h08);
    rd(4'd11, d); check("R8 no hit before threshold", 64'(d), 64'h0);
    const_ev(1, 8'h08);
    rd(4'd11, d); check("R8 hit with enable off", 64'(d), 64'h4);
    check("R9 irq low while disabled", 64'(irq_o), 64'h0);
    const_ev(3, 8'h08);
    rd(4'd11, d); check("R8 active held", 64'(d), 64'h4);
    wr(4'd10, 32'h4);
    check("R9 irq raised", 64'(irq_o), 64'h1);
    wr(4'd11, 32'h1);
    rd(4'd11, d); check("R10 zero bits untouched", 64'(d), 64'h4);
    wr(4'd11, 32'h4);
    rd(4'd11, d); check("R10 active cleared", 64'(d), 64'h0);
    rd(4'd10, d); check("R10 enable dropped", 64'(d), 64'h0);
    check("R9 irq low after clear", 64'(irq_o), 64'h0);
    wr(4'd3, 32'h0);

    // R11 condition names
    wr(4'd12, 32'd3);
    rd(4'd13, d); check("R11 name word 0", 64'(d), 64'h646E_6F63);
    rd(4'd14, d); check("R11 name word 1 idx3", 64'(d), 64'h3330);
    wr(4'd12, 32'd7);
    rd(4'd14, d); check("R11 name word 1 idx7", 64'(d), 64'h3730);
    wr(4'd12, 32'd11);
    rd(4'd13, d); check("R11 out-of-range name", 64'(d), 64'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule